// File: doc/BRIEF.md
# Bus Hold Handshake Controller

This block decides who drives the external memory bus: the local CPU or an outside device. The outside device asks for the bus by pulling an active-low hold request low. The controller passes that request through a synchroniser. It then waits for the current external bus cycle to end, and grants the bus by pulling an active-low hold acknowledge low. While the grant lasts, the address lines float and the strobes are only weakly driven. The outside device returns the bus by releasing its request, and the controller then takes the bus back.

While the bus is held, the controller reports the CPU's needs through an active-low bus request. It raises that request when an external access is pending, or when an interrupt needs external memory. It also stalls the CPU while an external access waits. Interrupts are signalled on an active-low interrupt-out line. When that line is driven depends on the hold phase and on whether the CPU is running from internal memory.

The protocol works only after the three pins have been switched to their hold function, and only while a hold-enable bit is set. The pin switch cannot be undone before reset. The enable bit may be changed at any time.

Top module: `bus_hold_ctrl`

## Requirements
- R1: With the protocol active, idle and no external cycle in progress, `hold_ack_n` goes low on the third rising clock edge after `hold_req_n` goes low, because of the two-flop input synchroniser.
- R2: While `cycle_active` is high, no grant is given. The grant follows on the first edge at which `cycle_active` is low.
- R3: `bus_float` is high exactly while `hold_ack_n` is low.
- R4: After `hold_req_n` returns high, `hold_ack_n` goes high on the third rising edge, and `bus_req_n` goes high at that same edge.
- R5: While the bus is held, `ext_pending` high drives `bus_req_n` low and `cpu_stall` high in the same cycle. Outside hold, both stay inactive.
- R6: An `irq` pulse while the bus is held with `exec_internal` high drives `int_out_n` low from the next edge for INT_LEN cycles (4 by default), and does not raise a bus request.
- R7: An `irq` pulse while the bus is held with `exec_internal` low drives `bus_req_n` low from the next edge and keeps `int_out_n` high. An INT_LEN-cycle low pulse on `int_out_n` starts at the edge where `hold_ack_n` rises.
- R8: An `irq` pulse after the request has been seen but before it has been granted drives `int_out_n` low from the next edge. `int_out_n` stays low through the grant and rises at the same edge as `hold_ack_n`.
- R9: With `hold_en` low, a low `hold_req_n` produces no new grant. Setting `hold_en` while the synchronised request is still low grants on the next edge.
- R10: A one-cycle `pin_sel` pulse sets `pins_locked`, which then stays high until reset. Before the lock, `hold_req_n` is ignored.
- R11: `pin_view` is `{hold_ack_n, bus_req_n, hold_req_n}` while the pins are locked and 3'b111 otherwise.
- R12: During reset, `hold_ack_n`, `bus_req_n` and `int_out_n` are high and `bus_float`, `cpu_stall` and `pins_locked` are low.
- R13: An `irq` pulse outside hold drives `int_out_n` low from the next edge for INT_LEN cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req_n | input | 1 | Active-low hold request from the outside device |
| hold_en | input | 1 | Hold-enable bit |
| pin_sel | input | 1 | Switches the three pins to the hold function (permanent until reset) |
| cycle_active | input | 1 | An external bus cycle is in progress |
| ext_pending | input | 1 | The CPU has an external access waiting |
| irq | input | 1 | Interrupt request pulse |
| exec_internal | input | 1 | The CPU is running from internal memory |
| hold_ack_n | output | 1 | Active-low hold acknowledge |
| bus_req_n | output | 1 | Active-low bus request |
| int_out_n | output | 1 | Active-low interrupt-out |
| bus_float | output | 1 | Float the address bus and weakly drive the strobes |
| cpu_stall | output | 1 | Stall the CPU until the bus is returned |
| pins_locked | output | 1 | The pins are committed to the hold function |
| pin_view | output | 3 | Live pin values for readback |

## Verification
The bench raises an interrupt in the narrow window between a seen request and its grant. A design that missed this window would either drop the interrupt or release `int_out_n` before `hold_ack_n`. It also interrupts a held bus with external execution. A design that got this wrong would pulse `int_out_n` at once instead of raising a bus request and waiting for the hold to end. Further tests hold `cycle_active` high for many cycles to catch a grant given in the middle of a cycle, and pulse `pin_sel` once to catch a lock that falls back when the input drops. Every latency is checked on the exact edge, so a missing or extra synchroniser stage shows up.

// File: rtl/bhc_pkg.sv
package bhc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_HELD = 2'd2
  } hold_st_e;
endpackage

// File: rtl/bhc_sync.sv
module bhc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/bhc_fsm.sv
module bhc_fsm
  import bhc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     proto_on,
  input  logic     hold_sync,
  input  logic     cycle_active,
  output hold_st_e state,
  output hold_st_e state_nxt
);
  hold_st_e state_q;

  always_comb begin
    state_nxt = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (proto_on && hold_sync)
          state_nxt = cycle_active ? ST_PEND : ST_HELD;
      end
      ST_PEND: begin
        if (!hold_sync || !proto_on) state_nxt = ST_IDLE;
        else if (!cycle_active)      state_nxt = ST_HELD;
      end
      ST_HELD: begin
        if (!hold_sync) state_nxt = ST_IDLE;
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_nxt;
  end

  assign state = state_q;
endmodule

// File: rtl/bhc_int.sv
module bhc_int
  import bhc_pkg::*;
#(
  parameter int INT_LEN = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  hold_st_e state,
  input  hold_st_e state_nxt,
  input  logic     irq,
  input  logic     exec_internal,
  output logic     int_out,
  output logic     defer_req
);
  localparam int CNT_W = $clog2(INT_LEN + 1);

  logic             race_q, race_d;
  logic             defer_q, defer_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             leaving, start;

  assign leaving = (state != ST_IDLE) && (state_nxt == ST_IDLE);

  always_comb begin
    start = 1'b0;
    if (state == ST_IDLE && irq)                   start = 1'b1;
    if (state == ST_HELD && irq && exec_internal)  start = 1'b1;
    if (leaving && (defer_q || irq))               start = 1'b1;
  end

  always_comb begin
    race_d  = race_q;
    defer_d = defer_q;
    if (state_nxt == ST_IDLE) begin
      race_d  = 1'b0;
      defer_d = 1'b0;
    end else begin
      if (state == ST_PEND && irq) race_d = 1'b1;
      if (state == ST_HELD && irq && !exec_internal) defer_d = 1'b1;
    end
  end

  always_comb begin
    if (start)              cnt_d = CNT_W'(INT_LEN);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      race_q  <= 1'b0;
      defer_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      race_q  <= race_d;
      defer_q <= defer_d;
      cnt_q   <= cnt_d;
    end
  end

  assign int_out   = race_q || (cnt_q != '0);
  assign defer_req = defer_q;
endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl
  import bhc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int INT_LEN     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold_req_n,
  input  logic       hold_en,
  input  logic       pin_sel,
  input  logic       cycle_active,
  input  logic       ext_pending,
  input  logic       irq,
  input  logic       exec_internal,
  output logic       hold_ack_n,
  output logic       bus_req_n,
  output logic       int_out_n,
  output logic       bus_float,
  output logic       cpu_stall,
  output logic       pins_locked,
  output logic [2:0] pin_view
);
  logic     rst_sync_n;
  logic     hold_sync;
  logic     locked_q;
  logic     proto_on;
  logic     int_out;
  logic     defer_req;
  logic     held;
  hold_st_e state, state_nxt;

  // reset: asserted at once, released on a clock edge
  bhc_sync #(.STAGES(2), .RST_VAL(1'b0)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  bhc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_hold_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(~hold_req_n), .q(hold_sync)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  locked_q <= 1'b0;
    else if (pin_sel) locked_q <= 1'b1;
  end

  assign proto_on = locked_q && hold_en;

  bhc_fsm i_fsm (
    .clk(clk), .rst_n(rst_sync_n), .proto_on(proto_on),
    .hold_sync(hold_sync), .cycle_active(cycle_active),
    .state(state), .state_nxt(state_nxt)
  );

  bhc_int #(.INT_LEN(INT_LEN)) i_int (
    .clk(clk), .rst_n(rst_sync_n), .state(state), .state_nxt(state_nxt),
    .irq(irq), .exec_internal(exec_internal),
    .int_out(int_out), .defer_req(defer_req)
  );

  assign held        = (state == ST_HELD);
  assign hold_ack_n  = ~held;
  assign bus_float   = held;
  assign bus_req_n   = ~(held && (ext_pending || defer_req));
  assign cpu_stall   = held && ext_pending;
  assign int_out_n   = ~int_out;
  assign pins_locked = locked_q;
  assign pin_view    = locked_q ? {hold_ack_n, bus_req_n, hold_req_n} : 3'b111;
endmodule

// File: rtl/bhc_checker.sv
module bhc_checker (
  input logic clk,
  input logic rst_n,
  input logic hold_req_n,
  input logic cycle_active,
  input logic ext_pending,
  input logic hold_ack_n,
  input logic bus_req_n,
  input logic bus_float,
  input logic cpu_stall,
  input logic pins_locked
);
  a_r2_grant_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack_n) |-> !$past(cycle_active));

  a_r3_float_tracks_ack: assert property (@(posedge clk) disable iff (!rst_n)
    bus_float == !hold_ack_n);

  a_r4_release_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack_n) |-> ($past(hold_req_n, 3) && bus_req_n));

  a_r5_breq_only_held: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req_n |-> !hold_ack_n);

  a_r5_stall_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> (ext_pending && !hold_ack_n && !bus_req_n));

  a_r10_lock_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    pins_locked |=> pins_locked);

  a_r10_no_grant_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !pins_locked |-> hold_ack_n);
endmodule

bind bus_hold_ctrl bhc_checker i_bhc_checker (
  .clk(clk), .rst_n(rst_n), .hold_req_n(hold_req_n),
  .cycle_active(cycle_active), .ext_pending(ext_pending),
  .hold_ack_n(hold_ack_n), .bus_req_n(bus_req_n), .bus_float(bus_float),
  .cpu_stall(cpu_stall), .pins_locked(pins_locked)
);

// File: tb/test_bus_hold_ctrl.sv
`timescale 1ns/1ps
module test_bus_hold_ctrl;
  logic       clk = 1'b0;
  logic       rst_n, hold_req_n, hold_en, pin_sel, cycle_active;
  logic       ext_pending, irq, exec_internal;
  logic       hold_ack_n, bus_req_n, int_out_n, bus_float, cpu_stall, pins_locked;
  logic [2:0] pin_view;
  int         checks = 0;
  int         failures = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  bus_hold_ctrl i_bus_hold_ctrl (
    .clk(clk), .rst_n(rst_n), .hold_req_n(hold_req_n), .hold_en(hold_en),
    .pin_sel(pin_sel), .cycle_active(cycle_active), .ext_pending(ext_pending),
    .irq(irq), .exec_internal(exec_internal), .hold_ack_n(hold_ack_n),
    .bus_req_n(bus_req_n), .int_out_n(int_out_n), .bus_float(bus_float),
    .cpu_stall(cpu_stall), .pins_locked(pins_locked), .pin_view(pin_view)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_irq();
    irq = 1'b1;
    @(negedge clk);
    irq = 1'b0;
  endtask

  task automatic enter_hold();
    hold_req_n = 1'b0;
    edges(3);
  endtask

  task automatic leave_hold();
    hold_req_n = 1'b1;
    edges(3);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; hold_req_n = 1'b1; hold_en = 1'b1; pin_sel = 1'b0;
    cycle_active = 1'b0; ext_pending = 1'b0; irq = 1'b0; exec_internal = 1'b1;
    #25;
    chk("R12 reset ack/breq/int", {1'b0, hold_ack_n, bus_req_n, int_out_n}, 4'b0111);
    chk("R12 reset float/stall/lock", {1'b0, bus_float, cpu_stall, pins_locked}, 4'b0000);
    @(negedge clk); rst_n = 1'b1;
    edges(4);
  endtask

  task automatic t_lock();
    hold_req_n = 1'b0;
    edges(5);
    chk("R10 unlocked ignores request", {3'b0, hold_ack_n}, 4'b0001);
    chk("R11 unlocked view", {1'b0, pin_view}, 4'b0111);
    hold_req_n = 1'b1;
    edges(3);
    pin_sel = 1'b1;
    @(negedge clk);
    pin_sel = 1'b0;
    chk("R10 lock set", {3'b0, pins_locked}, 4'b0001);
    edges(6);
    chk("R10 lock stays", {3'b0, pins_locked}, 4'b0001);
  endtask

  task automatic t_grant();
    hold_req_n = 1'b0;
    edges(2);
    chk("R1 no grant after two edges", {3'b0, hold_ack_n}, 4'b0001);
    edges(1);
    chk("R1 grant on third edge", {3'b0, hold_ack_n}, 4'b0000);
    chk("R3 float during hold", {3'b0, bus_float}, 4'b0001);
    chk("R11 locked view in hold", {1'b0, pin_view}, 4'b0010);
    hold_req_n = 1'b1;
    edges(2);
    chk("R4 still held after two edges", {3'b0, hold_ack_n}, 4'b0000);
    edges(1);
    chk("R4 released on third edge", {2'b0, hold_ack_n, bus_float}, 4'b0010);
  endtask

  task automatic t_boundary();
    cycle_active = 1'b1;
    hold_req_n = 1'b0;
    edges(10);
    chk("R2 no grant mid cycle", {3'b0, hold_ack_n}, 4'b0001);
    cycle_active = 1'b0;
    edges(1);
    chk("R2 grant at boundary", {3'b0, hold_ack_n}, 4'b0000);
    leave_hold();
  endtask

  task automatic t_pending();
    ext_pending = 1'b1;
    #1;
    chk("R5 no request outside hold", {2'b0, bus_req_n, cpu_stall}, 4'b0010);
    @(negedge clk);
    enter_hold();
    chk("R5 request and stall in hold", {2'b0, bus_req_n, cpu_stall}, 4'b0001);
    hold_req_n = 1'b1;
    edges(2);
    chk("R4 request kept before release", {2'b0, bus_req_n, hold_ack_n}, 4'b0000);
    edges(1);
    chk("R4 request drops with ack", {1'b0, bus_req_n, hold_ack_n, cpu_stall}, 4'b0110);
    ext_pending = 1'b0;
    edges(1);
  endtask

  task automatic t_irq_internal();
    enter_hold();
    exec_internal = 1'b1;
    pulse_irq();
    chk("R6 int asserted, no request", {1'b0, int_out_n, bus_req_n, hold_ack_n}, 4'b0010);
    edges(3);
    chk("R6 int still low", {3'b0, int_out_n}, 4'b0000);
    edges(1);
    chk("R6 int ends after INT_LEN", {3'b0, int_out_n}, 4'b0001);
    leave_hold();
  endtask

  task automatic t_irq_external();
    enter_hold();
    exec_internal = 1'b0;
    pulse_irq();
    chk("R7 request raised, int held off", {1'b0, int_out_n, bus_req_n, hold_ack_n}, 4'b0100);
    hold_req_n = 1'b1;
    edges(2);
    chk("R7 int still off before release", {2'b0, int_out_n, hold_ack_n}, 4'b0010);
    edges(1);
    chk("R7 int with release", {1'b0, int_out_n, bus_req_n, hold_ack_n}, 4'b0011);
    edges(3);
    chk("R7 int pulse continues", {3'b0, int_out_n}, 4'b0000);
    edges(1);
    chk("R7 int pulse ends", {3'b0, int_out_n}, 4'b0001);
    exec_internal = 1'b1;
  endtask

  task automatic t_race();
    cycle_active = 1'b1;
    hold_req_n = 1'b0;
    edges(3);
    pulse_irq();
    chk("R8 int before grant", {2'b0, int_out_n, hold_ack_n}, 4'b0001);
    edges(6);
    chk("R8 int held while pending", {2'b0, int_out_n, hold_ack_n}, 4'b0001);
    cycle_active = 1'b0;
    edges(1);
    chk("R8 ack and int together", {2'b0, int_out_n, hold_ack_n}, 4'b0000);
    hold_req_n = 1'b1;
    edges(2);
    chk("R8 both held before release", {2'b0, int_out_n, hold_ack_n}, 4'b0000);
    edges(1);
    chk("R8 both released together", {2'b0, int_out_n, hold_ack_n}, 4'b0011);
  endtask

  task automatic t_enable();
    hold_en = 1'b0;
    hold_req_n = 1'b0;
    edges(5);
    chk("R9 disabled ignores request", {3'b0, hold_ack_n}, 4'b0001);
    hold_en = 1'b1;
    edges(1);
    chk("R9 grant after enable", {3'b0, hold_ack_n}, 4'b0000);
    leave_hold();
  endtask

  task automatic t_irq_idle();
    pulse_irq();
    chk("R13 int outside hold", {2'b0, int_out_n, hold_ack_n}, 4'b0001);
    edges(3);
    chk("R13 int still low", {3'b0, int_out_n}, 4'b0000);
    edges(1);
    chk("R13 int ends", {3'b0, int_out_n}, 4'b0001);
  endtask

  initial begin
    t_reset();
    t_lock();
    t_grant();
    t_boundary();
    t_pending();
    t_irq_internal();
    t_irq_external();
    t_race();
    t_enable();
    t_irq_idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule